// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master of an Ethernet MAC. It drives the MDC clock and the bidirectional MDIO data line of an external PHY through three pins: a data output, an output enable and a data input. Software runs it through a 32-bit register port with three word slots. An address slot holds the target register address, the PHY port address and the MMD device address. A command slot holds the data word, the opcode, the MDC divider code and a busy flag. A clause slot chooses between Clause 22 and Clause 45 framing.

Software first writes the address slot. It then writes the command slot with busy set and a non-zero opcode. The block builds the serial frame or frames and shifts them out, MSB first. For reads it releases MDIO for the turnaround and data bits and collects the PHY's reply. When the last bit time ends, busy drops. For a read, the reply is then waiting in the low 16 bits of the command slot. In Clause 45 mode every access takes two frames: an address frame, then a data frame.

Top module: `mdio_host_ctl`

## Requirements
- R1: After reset the address slot reads 0, the command slot reads 0 and the clause slot reads 0xF. MDC and the MDIO output enable are low.
- R2: Register map, selected by `reg_sel`: 0 is the address slot, 1 the command slot, 2 the clause slot and 3 is unused. Slot 3 reads 0 and ignores writes.
  - Address slot fields: register address in bits 15:0, port address in bits 20:16, device address in bits 25:21.
  - Command slot fields: data in bits 15:0, opcode in bits 17:16, divider code in bits 21:19, busy in bit 22.
  - Bit 18 of the command slot, and every bit not listed, reads 0.
  - Read data on `reg_rdata` appears one clock after `reg_sel` is applied.
- R3: Writing the command slot with bit 22 set and a non-zero opcode, while idle, starts a transaction. Busy reads 1 until the last bit time of the last frame ends, and then reads 0. MDC and the output enable are low whenever busy is 0.
- R4: A command write with opcode 0 stores its fields but starts nothing. Busy stays 0 and MDC stays low.
- R5: Clause 22 frame layout, in wire order:
  - 32 ones of preamble.
  - ST=01.
  - OP=01 for opcode 1 (write) and OP=10 for opcodes 2 and 3.
  - The 5-bit port address.
  - The low 5 bits of the register address. The device field and the upper register-address bits are not sent.
  - TA=10 for writes.
  - 16 data bits, MSB first.
- R6: Clause 45 sends two 64-bit frames back to back.
  - The first is an address frame: preamble, ST=00, OP=00, port, device, TA=10, and the 16-bit register address.
  - The second is a data frame: ST=00, OP equal to the opcode (01 write, 11 read, 10 post-read-increment), port, device, and TA plus data.
- R7: The divider code sets the length of one bit time in system clocks: codes 0 to 7 give 8, 16, 32, 64, 96, 128, 192 and 256. MDC is low for the first half of each bit time and high for the second half.
- R8: MDIO output and output enable change only at a falling MDC edge, at the start of a transaction, or at its end. Inbound data is sampled at the rising MDC edge.
- R9: In the last frame of a read (opcode 2 or 3), the output enable is low for the two turnaround bits and the 16 data bits. The 16 sampled bits replace command-slot bits 15:0 when busy clears. A write leaves bits 15:0 unchanged.
- R10: A command-slot write while busy is 1 is ignored. Its data, opcode and divider do not reach the register or the wire.
- R11: An address-slot write while busy is 1 updates the slot's readback but does not alter the frame in flight.
- R12: A clause value of 0xF selects Clause 22. Any other value, including 0x0, selects Clause 45. The mode is captured when a transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected slot |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The hardest situation to reach is a register write that lands while a transaction is in flight. For the command slot it must be dropped; for the address slot it must show in readback without touching the wire. The stimulus gets there by launching a slow Clause 45 read, with a bit time of 32 clocks and two frames. In the middle of that read it issues a conflicting command write and a new address. The reference model then checks every MDC phase, enable and data bit against the original frames, and checks the final readback of both slots. A simple PHY responder drives the reply during the released bits. This makes the turnaround and sampling edge observable through the returned data word.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;
  localparam int REG_W    = 32;
  localparam int FRAME_W  = 64;
  localparam int PRE_W    = 32;
  localparam int DATA_W   = 16;
  localparam int CNT_W    = 8;

  localparam int PORT_LSB = 16;
  localparam int DEV_LSB  = 21;
  localparam int OPC_LSB  = 16;
  localparam int DIV_LSB  = 19;
  localparam int BUSY_BIT = 22;

  localparam logic [1:0] SEL_ADDR   = 2'd0;
  localparam logic [1:0] SEL_CMD    = 2'd1;
  localparam logic [1:0] SEL_CLAUSE = 2'd2;

  localparam logic [1:0] OPC_RSV = 2'd0;
  localparam logic [1:0] OPC_WR  = 2'd1;

  localparam logic [3:0] CLAUSE22_CODE = 4'hF;

  // Half of one MDC bit time, in system clocks.
  function automatic logic [CNT_W-1:0] half_period(input logic [2:0] code);
    case (code)
      3'd0: half_period = CNT_W'(4);
      3'd1: half_period = CNT_W'(8);
      3'd2: half_period = CNT_W'(16);
      3'd3: half_period = CNT_W'(32);
      3'd4: half_period = CNT_W'(48);
      3'd5: half_period = CNT_W'(64);
      3'd6: half_period = CNT_W'(96);
      default: half_period = CNT_W'(128);
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(
      input logic [1:0] st, input logic [1:0] op, input logic [4:0] fa,
      input logic [4:0] fb, input logic [1:0] ta, input logic [DATA_W-1:0] dat);
    build_frame = {{PRE_W{1'b1}}, st, op, fa, fb, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = run && (cnt == half - CNT_W'(1));
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int FRAME_W = 64,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_a,
  input  logic [FRAME_W-1:0] frame_b,
  input  logic               two_frames,
  input  logic               is_read,
  input  logic               rise_stb,
  input  logic               fall_stb,
  input  logic               mdio_in,
  output logic               active,
  output logic               mdio_out,
  output logic               mdio_oe,
  output logic               finish,
  output logic [DATA_W-1:0]  rd_word
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] REL_PRE  = BIT_W'(FRAME_W - DATA_W - 3);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] next_q;
  logic               two_q;
  logic               rd_q;
  logic               second_q;
  logic [BIT_W-1:0]   bitn;
  logic [DATA_W-1:0]  rd_sh;
  logic               last_frame;

  assign last_frame = second_q || !two_q;
  assign finish     = active && fall_stb && (bitn == LAST_IDX) && last_frame;
  assign mdio_out   = shreg[FRAME_W-1];
  assign rd_word    = rd_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      shreg    <= '1;
      next_q   <= '1;
      two_q    <= 1'b0;
      rd_q     <= 1'b0;
      second_q <= 1'b0;
      bitn     <= '0;
      rd_sh    <= '0;
      mdio_oe  <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active   <= 1'b1;
        shreg    <= frame_a;
        next_q   <= frame_b;
        two_q    <= two_frames;
        rd_q     <= is_read;
        second_q <= 1'b0;
        bitn     <= '0;
        mdio_oe  <= 1'b1;
      end
    end else begin
      if (rise_stb) begin
        rd_sh <= {rd_sh[DATA_W-2:0], mdio_in};
      end
      if (fall_stb) begin
        if (bitn == LAST_IDX) begin
          if (last_frame) begin
            active  <= 1'b0;
            shreg   <= '1;
            mdio_oe <= 1'b0;
          end else begin
            second_q <= 1'b1;
            bitn     <= '0;
            shreg    <= next_q;
            mdio_oe  <= 1'b1;
          end
        end else begin
          bitn    <= bitn + BIT_W'(1);
          shreg   <= {shreg[FRAME_W-2:0], 1'b1};
          mdio_oe <= !(rd_q && last_frame && (bitn >= REL_PRE));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_host_ctl.sv
module mdio_host_ctl
  import mdio_host_pkg::*;
#(
  parameter int DIV_CNT_W = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  input  logic             mdio_in
);
  localparam int ADDR_W = DEV_LSB + 5;

  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  dat_q;
  logic [1:0]         opc_q;
  logic [2:0]         div_q;
  logic [3:0]         clause_q;

  logic               busy_w;
  logic               cmd_wr;
  logic               launch;
  logic               finish;
  logic               rise_stb;
  logic               fall_stb;
  logic [DATA_W-1:0]  rd_word;
  logic [1:0]         new_op;
  logic [DATA_W-1:0]  new_dat;
  logic               new_rd;
  logic               use_c22;
  logic [1:0]         ta_bits;
  logic [FRAME_W-1:0] frame_a;
  logic [FRAME_W-1:0] frame_b;
  logic               two_frames;
  logic [4:0]         port_f;
  logic [4:0]         dev_f;
  logic [DATA_W-1:0]  rega_f;
  logic [5:0]         unused_wbits;

  assign unused_wbits = reg_wdata[REG_W-1:ADDR_W];

  assign cmd_wr  = reg_we && (reg_sel == SEL_CMD) && !busy_w;
  assign new_op  = reg_wdata[OPC_LSB +: 2];
  assign new_dat = reg_wdata[DATA_W-1:0];
  assign launch  = cmd_wr && reg_wdata[BUSY_BIT] && (new_op != OPC_RSV);
  assign new_rd  = (new_op != OPC_WR);
  assign use_c22 = (clause_q == CLAUSE22_CODE);
  assign ta_bits = new_rd ? 2'b11 : 2'b10;
  assign port_f  = addr_q[PORT_LSB +: 5];
  assign dev_f   = addr_q[DEV_LSB +: 5];
  assign rega_f  = addr_q[DATA_W-1:0];

  always_comb begin
    if (use_c22) begin
      frame_a    = build_frame(2'b01, new_rd ? 2'b10 : 2'b01, port_f, rega_f[4:0],
                               ta_bits, new_dat);
      frame_b    = frame_a;
      two_frames = 1'b0;
    end else begin
      frame_a    = build_frame(2'b00, 2'b00, port_f, dev_f, 2'b10, rega_f);
      frame_b    = build_frame(2'b00, new_op, port_f, dev_f, ta_bits, new_dat);
      two_frames = 1'b1;
    end
  end

  mdio_clk_div #(.CNT_W(DIV_CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_w),
    .half     (DIV_CNT_W'(half_period(div_q))),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (launch),
    .frame_a    (frame_a),
    .frame_b    (frame_b),
    .two_frames (two_frames),
    .is_read    (new_rd),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .mdio_in    (mdio_in),
    .active     (busy_w),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .finish     (finish),
    .rd_word    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      dat_q    <= '0;
      opc_q    <= OPC_RSV;
      div_q    <= '0;
      clause_q <= CLAUSE22_CODE;
    end else begin
      if (reg_we && (reg_sel == SEL_ADDR)) begin
        addr_q <= reg_wdata[ADDR_W-1:0];
      end
      if (reg_we && (reg_sel == SEL_CLAUSE)) begin
        clause_q <= reg_wdata[3:0];
      end
      if (cmd_wr) begin
        dat_q <= new_dat;
        opc_q <= new_op;
        div_q <= reg_wdata[DIV_LSB +: 3];
      end else if (finish && (opc_q != OPC_WR)) begin
        dat_q <= rd_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        SEL_ADDR:   reg_rdata <= REG_W'(addr_q);
        SEL_CMD:    reg_rdata <= REG_W'({busy_w, div_q, 1'b0, opc_q, dat_q});
        SEL_CLAUSE: reg_rdata <= REG_W'(clause_q);
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_host_ctl_chk.sv
module mdio_host_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata
);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R3
  end_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(mdc));

  // R4
  rsv_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd1 && reg_wdata[17:16] == 2'b00 && !busy) |=> !busy);

  // R7
  mdc_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> busy);

  // R8
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R8
  oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_oe) |-> ($fell(mdc) || $rose(busy) || $fell(busy)));
endmodule

bind mdio_host_ctl mdio_host_ctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .busy      (busy_w),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata)
);

// File: tb/mdio_host_ctl_bench.sv
module mdio_host_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int vecs = 0;
  int fails = 0;

  bit          eb[$];
  bit          eo[$];
  int          m_half = 4;
  int          m_total = 0;
  int          m_t = 0;
  bit          m_run = 0;
  bit          m_go = 0;
  int          m_nfr = 1;
  logic [15:0] m_resp = '0;
  string       m_tag = "R5";
  logic [25:0] sh_addr = '0;
  logic [3:0]  sh_cl = 4'hF;

  always #2 clk = ~clk;

  mdio_host_ctl u_mdio_host_ctl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int half_of(input int code);
    case (code)
      0: return 4;   1: return 8;   2: return 16;  3: return 32;
      4: return 48;  5: return 64;  6: return 96;  default: return 128;
    endcase
  endfunction

  function automatic logic [31:0] cmdv(input bit busy, input int div, input int op,
                                       input logic [15:0] d);
    return (32'(busy) << 22) | (32'(div) << 19) | (32'(op) << 16) | 32'(d);
  endfunction

  task automatic push(input logic [15:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) eb.push_back(v[i]);
  endtask

  task automatic add_frame(input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] a, input logic [4:0] b,
                           input logic [15:0] d, input bit rd);
    push(16'hFFFF, 16); push(16'hFFFF, 16);
    push(16'(st), 2); push(16'(op), 2); push(16'(a), 5); push(16'(b), 5);
    push(rd ? 16'd3 : 16'd2, 2); push(d, 16);
    for (int i = 0; i < 64; i++) eo.push_back(!(rd && i >= 46));
  endtask

  // Reference model: bit stream of the expected frames.
  task automatic launch(input int op, input int div, input logic [15:0] d,
                        input logic [15:0] resp, input string tag);
    bit rd;
    rd = (op != 1);
    eb.delete(); eo.delete();
    if (sh_cl == 4'hF) begin
      add_frame(2'b01, rd ? 2'b10 : 2'b01, sh_addr[20:16], sh_addr[4:0], d, rd);
      m_nfr = 1;
    end else begin
      add_frame(2'b00, 2'b00, sh_addr[20:16], sh_addr[25:21], sh_addr[15:0], 1'b0);
      eo.delete();
      for (int i = 0; i < 64; i++) eo.push_back(1'b1);
      add_frame(2'b00, 2'(op), sh_addr[20:16], sh_addr[25:21], d, rd);
      m_nfr = 2;
    end
    m_half = half_of(div);
    m_total = eb.size() * 2 * m_half;
    m_resp = resp;
    m_tag = tag;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd1;
    reg_wdata = cmdv(1'b1, div, op, d) | 32'h8004_0000;
    m_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; m_go = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel;
    @(posedge clk);
    @(negedge clk);
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_done;
    while (m_run) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst) m_run = 0;
    else if (m_go) begin m_run = 1; m_t = 0; end
    else if (m_run) begin
      m_t++;
      if (m_t >= m_total) m_run = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit e_mdc, e_oe, e_out;
      int g, b;
      g = 0; e_out = 1'b1;
      if (m_run) begin
        g = m_t / (2 * m_half);
        e_mdc = (m_t % (2 * m_half)) >= m_half;
        e_oe = eo[g];
        e_out = eb[g];
      end else begin
        e_mdc = 1'b0; e_oe = 1'b0;
      end
      chk(mdc === e_mdc, {"R7 mdc ", m_tag}, 32'(mdc), 32'(e_mdc));
      chk(mdio_oe === e_oe, {"R9 R3 oe ", m_tag}, 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk(mdio_out === e_out, {"R8 bit ", m_tag}, 32'(mdio_out), 32'(e_out));
      if (m_run) begin
        b = g % 64;
        mdio_in = ((g / 64) == (m_nfr - 1) && b >= 48) ? m_resp[63 - b] : 1'b1;
      end else begin
        mdio_in = 1'b1;
      end
    end
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(2'd0, 32'h0, "R1 addr");
    rd(2'd1, 32'h0, "R1 cmd");
    rd(2'd2, 32'hF, "R1 clause");
    // R2 layout, upper bits read zero, unused slot
    wr(2'd0, 32'hFC00_0000 | (32'h13 << 21) | (32'h0A << 16) | 32'h1234);
    sh_addr = 26'((32'h13 << 21) | (32'h0A << 16) | 32'h1234);
    rd(2'd0, 32'(sh_addr), "R2 addr");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R2 unused slot");
    // R5 C22 write, R3 busy
    launch(1, 0, 16'hA5C3, 16'h0, "R5 c22 write");
    rd(2'd1, cmdv(1, 0, 1, 16'hA5C3), "R3 busy set R2 bit18");
    wait_done();
    rd(2'd1, cmdv(0, 0, 1, 16'hA5C3), "R3 busy clear");
    // R5 C22 read, R9 data return
    launch(3, 1, 16'h0, 16'h3C5A, "R5 c22 read");
    wait_done();
    rd(2'd1, cmdv(0, 1, 3, 16'h3C5A), "R9 c22 read data");
    // R4 reserved opcode
    wr(2'd1, cmdv(1, 2, 0, 16'h1111));
    repeat (20) @(negedge clk);
    rd(2'd1, cmdv(0, 2, 0, 16'h1111), "R4 opcode 0");
    // R12 C45 via 0x0, R6 write
    wr(2'd2, 32'h0); sh_cl = 4'h0;
    rd(2'd2, 32'h0, "R12 clause readback");
    launch(1, 0, 16'hBEEF, 16'h0, "R6 c45 write");
    wait_done();
    rd(2'd1, cmdv(0, 0, 1, 16'hBEEF), "R6 c45 write fields");
    // R6 C45 read with R10 and R11 writes in flight
    launch(3, 2, 16'h0, 16'h8001, "R6 c45 read R11");
    wr(2'd1, cmdv(1, 5, 1, 16'h4444));
    wr(2'd0, (32'h01 << 21) | (32'h1F << 16) | 32'hABCD);
    rd(2'd0, (32'h01 << 21) | (32'h1F << 16) | 32'hABCD, "R11 addr readback");
    wait_done();
    sh_addr = 26'((32'h01 << 21) | (32'h1F << 16) | 32'hABCD);
    rd(2'd1, cmdv(0, 2, 3, 16'h8001), "R10 ignored cmd R9");
    // R12 other value selects C45, post-read-increment
    wr(2'd2, 32'h5); sh_cl = 4'h5;
    launch(2, 0, 16'h0, 16'h7FFE, "R12 c45 post-read");
    wait_done();
    rd(2'd1, cmdv(0, 0, 2, 16'h7FFE), "R12 post-read data");
    // R7 divider codes under C22
    wr(2'd2, 32'hF); sh_cl = 4'hF;
    for (int dv = 2; dv < 8; dv++) begin
      launch(1, dv, 16'h0F00 + 16'(dv), 16'h0, "R7 divider");
      wait_done();
      rd(2'd1, cmdv(0, dv, 1, 16'h0F00 + 16'(dv)), "R7 divider fields");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule